// File: doc/BRIEF.md
# Sliding-window grouped average aggregator

This block takes a stream of trade tuples and keeps, for each trading symbol, the average price over a window that spans three consecutive time intervals. A symbol is a four-byte ASCII code, first character in bits 31:24. The price is an unsigned count of cents. The sequence number and share volume of a tuple play no part in the average, so they are removed upstream before the tuple reaches this block. Symbols are held in a bounded table. An incoming symbol is compared against every valid table entry at once. A symbol that misses takes a free entry.

Each entry keeps a price sum and a tuple count for each of three interval slots. A pulse on `tick` closes the current interval. The block then stops accepting input and walks the table one entry per cycle. For every live group it emits the symbol and the integer quotient of its window sum by its window count. It then retires the oldest slot and frees every group that no longer has tuples in the window. After that it accepts input again.

Top module: `sym_window_avg`

## Requirements
- R1: After reset, in_ready is 1, and out_valid and overflow are both 0.
- R2: A tuple is taken only on a clock edge where in_valid and in_ready are both 1. Tuples and ticks offered while in_ready is 0 have no effect on any later result.
- R3: A symbol that is not in the table occupies the lowest-numbered free entry. Results come out in ascending entry order, one entry per cycle. An entry without a live group gives a cycle with out_valid low.
- R4: Count the edge that samples tick with in_ready high as edge 1. in_ready is then low after edges 1 to 34 and high again after edge 35.
- R5: out_avg is floor(S / C), where S is the sum of the prices and C is the number of tuples of that symbol accepted in the interval being closed and in the two intervals before it.
- R6: A tuple accepted in an interval that closed three or more ticks earlier contributes nothing to out_avg.
- R7: A tuple accepted on the same edge as the tick belongs to the interval that this tick closes.
- R8: When all NG entries hold groups, a tuple with a new symbol is dropped and sets overflow. overflow stays 1 until reset.
- R9: When the window advances after emission, a group with no tuples in the two intervals still in the window is freed. Its entry can then be taken by the next new symbol.
- R10: out_valid is 1 only in the emission cycles that follow a tick. It is 0 in every cycle where in_ready is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | A tuple is offered |
| in_sym | input | SYM_W (32) | Four-character symbol of the tuple |
| in_price | input | PRICE_W (16) | Price of the tuple in cents |
| tick | input | 1 | Closes the current interval (sampled while in_ready is 1) |
| in_ready | output | 1 | Block accepts tuples and ticks |
| out_valid | output | 1 | A result is present on out_sym and out_avg |
| out_sym | output | SYM_W (32) | Symbol of the result |
| out_avg | output | PRICE_W+CNT_W+2 (28) | Windowed average price of the result |
| overflow | output | 1 | Sticky flag: a tuple was dropped because the table was full |

## Verification
Count the tick edge as edge 1. The result for table entry i appears after edge i+3. in_ready returns after edge 35. The overflow flag changes one edge after the tuple that caused the drop was accepted.

The bench holds a behavioural model: symbol table, three interval slots and lowest-free allocation. From this model it computes the whole list of expected results at the tick. It then checks in_ready, out_valid and the result fields at every falling edge of the 35 cycles that follow. During those cycles it keeps offering a junk tuple and tick, so that the check for ignored input is made at the outputs.

// File: rtl/swa_pkg.sv
package swa_pkg;
   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_FLUSH = 2'd1,
      ST_EMIT  = 2'd2,
      ST_ADV   = 2'd3
   } swa_state_e;
endpackage

// File: rtl/swa_match.sv
module swa_match #(
   parameter int NG    = 32,
   parameter int SYM_W = 32,
   localparam int IDX_W = $clog2(NG)
) (
   input  logic [SYM_W-1:0]          key,
   input  logic [NG-1:0][SYM_W-1:0]  tab_sym,
   input  logic [NG-1:0]             tab_vld,
   output logic                      hit,
   output logic [IDX_W-1:0]          hit_idx,
   output logic                      free_any,
   output logic [IDX_W-1:0]          free_idx
);
   logic [NG-1:0] eq;

   for (genvar g = 0; g < NG; g++) begin : g_cmp
      assign eq[g] = tab_vld[g] && (tab_sym[g] == key);
   end

   always_comb begin
      hit      = |eq;
      free_any = ~&tab_vld;
      hit_idx  = '0;
      free_idx = '0;
      for (int g = NG - 1; g >= 0; g--) begin
         if (eq[g])       hit_idx  = IDX_W'(g);
         if (!tab_vld[g]) free_idx = IDX_W'(g);
      end
   end
endmodule

// File: rtl/swa_slots.sv
module swa_slots #(
   parameter int NG      = 32,
   parameter int NSLOT   = 3,
   parameter int PRICE_W = 16,
   parameter int CNT_W   = 10,
   localparam int IDX_W  = $clog2(NG),
   localparam int SLOT_W = $clog2(NSLOT),
   localparam int SUM_W  = PRICE_W + CNT_W,
   localparam int TSUM_W = SUM_W + SLOT_W,
   localparam int TCNT_W = CNT_W + SLOT_W
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               upd_en,
   input  logic [IDX_W-1:0]   upd_idx,
   input  logic [PRICE_W-1:0] upd_price,
   input  logic [SLOT_W-1:0]  cur_slot,
   input  logic               adv_en,
   input  logic [SLOT_W-1:0]  nxt_slot,
   input  logic [IDX_W-1:0]   rd_idx,
   output logic [TSUM_W-1:0]  rd_sum,
   output logic [TCNT_W-1:0]  rd_cnt,
   output logic [NG-1:0]      keep_live
);
   logic [NSLOT-1:0][SUM_W-1:0] slot_rs;
   logic [NSLOT-1:0][CNT_W-1:0] slot_rc;
   logic [NSLOT-1:0][NG-1:0]    slot_nz;

   for (genvar s = 0; s < NSLOT; s++) begin : g_slot
      logic [SUM_W-1:0] sum_q [NG];
      logic [CNT_W-1:0] cnt_q [NG];
      logic [NG-1:0]    nz;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            for (int g = 0; g < NG; g++) begin
               sum_q[g] <= '0;
               cnt_q[g] <= '0;
            end
         end else if (adv_en && (nxt_slot == SLOT_W'(s))) begin
            for (int g = 0; g < NG; g++) begin
               sum_q[g] <= '0;
               cnt_q[g] <= '0;
            end
         end else if (upd_en && (cur_slot == SLOT_W'(s))) begin
            sum_q[upd_idx] <= sum_q[upd_idx] + SUM_W'(upd_price);
            cnt_q[upd_idx] <= cnt_q[upd_idx] + CNT_W'(1);
         end
      end

      always_comb begin
         for (int g = 0; g < NG; g++) nz[g] = (cnt_q[g] != '0);
      end

      assign slot_rs[s] = sum_q[rd_idx];
      assign slot_rc[s] = cnt_q[rd_idx];
      assign slot_nz[s] = nz;
   end

   always_comb begin
      rd_sum    = '0;
      rd_cnt    = '0;
      keep_live = '0;
      for (int s = 0; s < NSLOT; s++) begin
         rd_sum = rd_sum + TSUM_W'(slot_rs[s]);
         rd_cnt = rd_cnt + TCNT_W'(slot_rc[s]);
         if (nxt_slot != SLOT_W'(s)) keep_live = keep_live | slot_nz[s];
      end
   end
endmodule

// File: rtl/swa_div.sv
module swa_div #(
   parameter int NUM_W     = 28,
   parameter int DEN_W     = 12,
   parameter bit ITERATIVE = 1'b0
) (
   input  logic [NUM_W-1:0] num,
   input  logic [DEN_W-1:0] den,
   output logic [NUM_W-1:0] quo
);
   if (DEN_W > NUM_W) begin : g_bad_w
      $error("swa_div: DEN_W must not exceed NUM_W");
   end

   if (!ITERATIVE) begin : g_op
      assign quo = (den == '0) ? '0 : num / NUM_W'(den);
   end else begin : g_shift
      logic [DEN_W:0] rem;
      always_comb begin
         rem = '0;
         quo = '0;
         for (int b = NUM_W - 1; b >= 0; b--) begin
            rem = {rem[DEN_W-1:0], num[b]};
            if (rem >= {1'b0, den}) begin
               rem    = rem - {1'b0, den};
               quo[b] = 1'b1;
            end
         end
         if (den == '0) quo = '0;
      end
   end
endmodule

// File: rtl/sym_window_avg.sv
module sym_window_avg
   import swa_pkg::*;
#(
   parameter int SYM_W    = 32,
   parameter int PRICE_W  = 16,
   parameter int CNT_W    = 10,
   parameter int NG       = 32,
   parameter int NSLOT    = 3,
   parameter bit DIV_ITER = 1'b0,
   localparam int IDX_W   = $clog2(NG),
   localparam int SLOT_W  = $clog2(NSLOT),
   localparam int TSUM_W  = PRICE_W + CNT_W + SLOT_W,
   localparam int TCNT_W  = CNT_W + SLOT_W
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               in_valid,
   input  logic [SYM_W-1:0]   in_sym,
   input  logic [PRICE_W-1:0] in_price,
   input  logic               tick,
   output logic               in_ready,
   output logic               out_valid,
   output logic [SYM_W-1:0]   out_sym,
   output logic [TSUM_W-1:0]  out_avg,
   output logic               overflow
);
   if (NSLOT < 2) begin : g_bad_slot
      $error("sym_window_avg: NSLOT must be at least 2");
   end
   if (NG < 2) begin : g_bad_ng
      $error("sym_window_avg: NG must be at least 2");
   end
   if ((SYM_W % 8) != 0) begin : g_bad_sym
      $error("sym_window_avg: SYM_W must hold whole characters");
   end

   swa_state_e                state_q;
   logic [IDX_W-1:0]          idx_q;
   logic [SLOT_W-1:0]         cur_q, nxt_slot;
   logic                      p_vld;
   logic [SYM_W-1:0]          p_sym;
   logic [PRICE_W-1:0]        p_price;
   logic [NG-1:0][SYM_W-1:0]  tab_sym;
   logic [NG-1:0]             tab_vld;
   logic                      hit, free_any;
   logic [IDX_W-1:0]          hit_idx, free_idx;
   logic                      accept, upd_en, alloc, drop, adv_en, emit_hit;
   logic [TSUM_W-1:0]         rd_sum, quo;
   logic [TCNT_W-1:0]         rd_cnt;
   logic [NG-1:0]             keep_live;

   assign in_ready = (state_q == ST_IDLE);
   assign accept   = in_valid && in_ready;
   assign upd_en   = p_vld && (hit || free_any);
   assign alloc    = p_vld && !hit && free_any;
   assign drop     = p_vld && !hit && !free_any;
   assign adv_en   = (state_q == ST_ADV);
   assign nxt_slot = (cur_q == SLOT_W'(NSLOT - 1)) ? '0 : cur_q + SLOT_W'(1);
   assign emit_hit = (state_q == ST_EMIT) && tab_vld[idx_q] && (rd_cnt != '0);

   // capture stage: the lookup runs on the registered tuple
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         p_vld   <= 1'b0;
         p_sym   <= '0;
         p_price <= '0;
      end else begin
         p_vld <= accept;
         if (accept) begin
            p_sym   <= in_sym;
            p_price <= in_price;
         end
      end
   end

   swa_match #(.NG(NG), .SYM_W(SYM_W)) u_match (
      .key(p_sym), .tab_sym(tab_sym), .tab_vld(tab_vld),
      .hit(hit), .hit_idx(hit_idx), .free_any(free_any), .free_idx(free_idx)
   );

   swa_slots #(.NG(NG), .NSLOT(NSLOT), .PRICE_W(PRICE_W), .CNT_W(CNT_W)) u_slots (
      .clk(clk), .rst_n(rst_n),
      .upd_en(upd_en), .upd_idx(hit ? hit_idx : free_idx), .upd_price(p_price),
      .cur_slot(cur_q), .adv_en(adv_en), .nxt_slot(nxt_slot),
      .rd_idx(idx_q), .rd_sum(rd_sum), .rd_cnt(rd_cnt), .keep_live(keep_live)
   );

   swa_div #(.NUM_W(TSUM_W), .DEN_W(TCNT_W), .ITERATIVE(DIV_ITER)) u_div (
      .num(rd_sum), .den(rd_cnt), .quo(quo)
   );

   // group table: allocation and release
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tab_vld  <= '0;
         tab_sym  <= '0;
         overflow <= 1'b0;
      end else begin
         if (alloc) begin
            tab_vld[free_idx] <= 1'b1;
            tab_sym[free_idx] <= p_sym;
         end
         if (adv_en) tab_vld <= tab_vld & keep_live;
         if (drop)   overflow <= 1'b1;
      end
   end

   // interval close: flush, scan, retire oldest slot
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         idx_q   <= '0;
         cur_q   <= '0;
      end else begin
         unique case (state_q)
            ST_IDLE:  if (tick) state_q <= ST_FLUSH;
            ST_FLUSH: begin
               state_q <= ST_EMIT;
               idx_q   <= '0;
            end
            ST_EMIT: begin
               if (idx_q == IDX_W'(NG - 1)) state_q <= ST_ADV;
               else                         idx_q   <= idx_q + IDX_W'(1);
            end
            ST_ADV: begin
               cur_q   <= nxt_slot;
               state_q <= ST_IDLE;
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_sym   <= '0;
         out_avg   <= '0;
      end else begin
         out_valid <= emit_hit;
         if (emit_hit) begin
            out_sym <= tab_sym[idx_q];
            out_avg <= quo;
         end
      end
   end
endmodule

// File: rtl/swa_chk.sv
module swa_chk (
   input logic clk,
   input logic rst_n,
   input logic tick,
   input logic in_ready,
   input logic out_valid,
   input logic overflow
);
   // R4
   tick_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && in_ready) |=> !in_ready);

   // R4
   stall_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(in_ready) |-> $past(tick));

   // R10
   emit_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> !in_ready);

   // R10
   resume_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(in_ready) |-> !out_valid);

   // R8
   ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      overflow |=> overflow);
endmodule

bind sym_window_avg swa_chk u_chk (
   .clk(clk), .rst_n(rst_n), .tick(tick),
   .in_ready(in_ready), .out_valid(out_valid), .overflow(overflow)
);

// File: tb/sym_window_avg_tb_top.sv
module sym_window_avg_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int NG = 32;
   localparam int NS = 3;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [31:0] in_sym = '0;
   logic [15:0] in_price = '0;
   logic        tick = 1'b0;
   logic        in_ready, out_valid, overflow;
   logic [31:0] out_sym;
   logic [27:0] out_avg;

   int n_chk = 0;
   int n_bad = 0;

   // behavioural reference model
   logic [31:0] m_sym [NG];
   bit          m_vld [NG];
   int          m_sum [NS][NG];
   int          m_cnt [NS][NG];
   int          m_cur = 0;
   bit          m_ovf = 0;
   bit          e_v   [NG];
   logic [31:0] e_sym [NG];
   int          e_avg [NG];

   always #(CLK_PERIOD / 2) clk = ~clk;

   sym_window_avg dut_i (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sym(in_sym),
      .in_price(in_price), .tick(tick), .in_ready(in_ready),
      .out_valid(out_valid), .out_sym(out_sym), .out_avg(out_avg),
      .overflow(overflow)
   );

   task automatic chk(bit ok, string tag, longint act, longint exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: got %0d expected %0d", tag, act, exp);
      end
   endtask

   function automatic void m_accept(logic [31:0] s, int p);
      int slot_i = -1;
      for (int g = 0; g < NG; g++) if (m_vld[g] && m_sym[g] == s) slot_i = g;
      if (slot_i < 0) begin
         for (int g = NG - 1; g >= 0; g--) if (!m_vld[g]) slot_i = g;
         if (slot_i < 0) begin
            m_ovf = 1;
            return;
         end
         m_vld[slot_i] = 1;
         m_sym[slot_i] = s;
      end
      m_sum[m_cur][slot_i] += p;
      m_cnt[m_cur][slot_i] += 1;
   endfunction

   function automatic void m_expect();
      for (int g = 0; g < NG; g++) begin
         int ts = 0;
         int tc = 0;
         for (int s = 0; s < NS; s++) begin
            ts += m_sum[s][g];
            tc += m_cnt[s][g];
         end
         e_v[g]   = m_vld[g] && (tc != 0);
         e_sym[g] = m_sym[g];
         e_avg[g] = (tc != 0) ? ts / tc : 0;
      end
   endfunction

   function automatic void m_advance();
      int nx = (m_cur + 1) % NS;
      for (int g = 0; g < NG; g++) begin
         int tc = 0;
         m_sum[nx][g] = 0;
         m_cnt[nx][g] = 0;
         for (int s = 0; s < NS; s++) tc += m_cnt[s][g];
         if (tc == 0) m_vld[g] = 0;
      end
      m_cur = nx;
   endfunction

   task automatic cyc(bit v, logic [31:0] s, int p);
      @(negedge clk);
      in_valid = v;
      in_sym   = s;
      in_price = 16'(p);
      tick     = 1'b0;
      if (v && in_ready) m_accept(s, p);
   endtask

   task automatic tick_emit(bit v, logic [31:0] s, int p, string tag);
      @(negedge clk);
      chk(in_ready == 1'b1, "R4 ready before tick", in_ready, 1);
      in_valid = v;
      in_sym   = s;
      in_price = 16'(p);
      tick     = 1'b1;
      if (v) m_accept(s, p);
      m_expect();
      for (int n = 1; n <= 35; n++) begin
         bit ev;
         @(negedge clk);
         ev = (n >= 3) && (n <= 34) && e_v[(n >= 3) ? n - 3 : 0];
         chk(in_ready == (n >= 35), "R4 ready window", in_ready, (n >= 35));
         chk(out_valid == ev, "R10 out_valid slot", out_valid, ev);
         if (ev) begin
            chk(out_sym == e_sym[n - 3], {tag, " symbol"}, out_sym, e_sym[n - 3]);
            chk(out_avg == 28'(e_avg[n - 3]), {tag, " average"}, out_avg, e_avg[n - 3]);
         end
         if (out_valid) chk(out_sym != "ZZZZ", "R2 ignored tuple", out_sym, 0);
         if (n <= 34) begin
            in_valid = 1'b1;
            in_sym   = "ZZZZ";
            in_price = 16'd999;
            tick     = 1'b1;
         end else begin
            in_valid = 1'b0;
            tick     = 1'b0;
         end
      end
      m_advance();
      chk(overflow == m_ovf, "R8 overflow flag", overflow, m_ovf);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

   initial begin
      for (int g = 0; g < NG; g++) begin
         m_vld[g] = 0;
         m_sym[g] = '0;
         for (int s = 0; s < NS; s++) begin
            m_sum[s][g] = 0;
            m_cnt[s][g] = 0;
         end
      end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1
      chk(in_ready == 1'b1, "R1 reset ready", in_ready, 1);
      chk(out_valid == 1'b0, "R1 reset out_valid", out_valid, 0);
      chk(overflow == 1'b0, "R1 reset overflow", overflow, 0);

      // R3: first allocations, ascending emission
      cyc(1, "AAAA", 100);
      cyc(1, "AAAA", 201);
      cyc(1, "BBBB", 50);
      cyc(0, '0, 0);
      tick_emit(0, '0, 0, "R3");

      // R7: tuple together with the tick
      cyc(1, "CCCC", 7);
      tick_emit(1, "AAAA", 3, "R7");

      // R5: three intervals in the window
      cyc(1, "BBBB", 10);
      tick_emit(0, '0, 0, "R5");

      // R6: oldest interval retired
      tick_emit(0, '0, 0, "R6");

      // R9: freed entries reused from the lowest index
      cyc(1, "DDDD", 9);
      cyc(1, "EEEE", 12);
      tick_emit(0, '0, 0, "R9");

      // R8: fill the table past capacity
      for (int i = 0; i < 33; i++) cyc(1, 32'h4E000000 + i, 20 + i);
      cyc(0, '0, 0);
      cyc(0, '0, 0);
      chk(overflow == 1'b1, "R8 overflow set", overflow, 1);
      tick_emit(0, '0, 0, "R8");
      cyc(0, '0, 0);
      chk(overflow == 1'b1, "R8 overflow sticky", overflow, 1);

      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end
endmodule